// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterised ring of test cells placed between a chip's core logic and its pads. Each cell holds a capture/shift stage and an update stage. The shift stages form one serial path, from `scan_in` through to `scan_out`. There are input cells and output cells, and the output cells come in pairs: one carries the pad data and the other carries the pad enable. A test access controller outside this block supplies the capture, shift and update strobes. The instruction logic supplies a three-bit mode code. From these, the block chooses whether the pads and the core see each other directly or see the update stage.

Capture and shift act on the rising edge of `tck`. The update stage loads on the falling edge while `update_en` is high. Pads driven from the update stage therefore change only after a complete shift sequence. Each mode treats capture, update and the pin multiplexers in its own way. Sample mode observes the pins without disturbing them. Preload mode fills the update stage quietly. The external and internal test modes put the update stage in control of the pads and the core. Clamp mode forces fixed pad levels, and high-impedance mode turns every pad driver off.

Top module: `bsr_chain`

## Requirements
- R1: While `trst_n` is low, every capture/shift stage and every update stage clears to 0. Once reset is released, `scan_out` reads 0, and external-test mode drives 0 on `pad_out`, `pad_oe` and `core_in` until an update occurs.
- R2: With `shift_en` high, each rising `tck` edge moves the chain one place toward `scan_out`, and `scan_in` enters at the far end. Chain position 0 is next to `scan_out`. Positions 0..N_IN-1 are input cells. Output pair k uses position N_IN+2k for data and N_IN+2k+1 for enable.
- R3: When `shift_en` and `capture_en` are both high, the chain shifts and does not capture.
- R4: Mode 1 (sample): capture loads `pad_in` into the input cells and loads `core_out`/`core_oe` into the output pairs. The pins stay in pass-through.
- R5: Mode 2 (preload): capture leaves the chain unchanged. Update loads the update stage. The pins stay in pass-through.
- R6: Mode 3 (external test): `pad_out`/`pad_oe` come from the update stage of each output pair, and `core_in` comes from the update stage of the input cells. Capture loads `pad_in` into the input cells only.
- R7: Mode 4 (internal test): the pins are driven as in mode 3. Capture loads `core_out`/`core_oe` into the output pairs only.
- R8: The update stage loads from the chain only on a falling `tck` edge with `update_en` high. Pads driven from the update stage keep their value while a new pattern is shifted in.
- R9: Modes 0 (normal) and 7 pass `core_out`→`pad_out`, `core_oe`→`pad_oe` and `pad_in`→`core_in`. In these modes capture and update have no effect.
- R10: Mode 5 (clamp): `pad_out` equals the CLAMP_VAL parameter and `pad_oe` is all ones.
- R11: Mode 6 (high impedance): `pad_oe` and `pad_out` are all zeros. In modes 5 and 6, `core_in` follows `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| mode | input | 3 | Mode code from instruction decode |
| capture_en | input | 1 | Capture strobe (data-register capture state) |
| shift_en | input | 1 | Shift strobe (data-register shift state) |
| update_en | input | 1 | Update strobe (data-register update state) |
| scan_in | input | 1 | Serial data into the far end of the chain |
| scan_out | output | 1 | Serial data from chain position 0 |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enable from the core |
| core_in | output | N_IN | Input data delivered to the core |
| pad_in | input | N_IN | Input data arriving at the pads |
| pad_out | output | N_OUT | Data driven to the pads |
| pad_oe | output | N_OUT | Pad driver enable |

## Verification
A wrong bit in the capture/shift stage is invisible at the pins. It appears at `scan_out` during the next shift, after as many `tck` cycles as its position number. A wrong update-stage bit appears on `pad_out`, `pad_oe` or `core_in` as soon as mode 3 or 4 is selected, with no clock needed. A wrong pin-mux selection appears combinationally in the same cycle as the mode change. For these reasons the checks read the chain back through a full shift, and they inspect the pins right after each update and each mode switch.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_SAMPLE  = 3'd1,
        MODE_PRELOAD = 3'd2,
        MODE_EXTEST  = 3'd3,
        MODE_INTEST  = 3'd4,
        MODE_CLAMP   = 3'd5,
        MODE_HIGHZ   = 3'd6,
        MODE_RSVD    = 3'd7
    } bsr_mode_e;

    // input cells take the pad value on capture
    function automatic logic grabs_inputs(bsr_mode_e m);
        return (m == MODE_SAMPLE) || (m == MODE_EXTEST);
    endfunction

    // output pairs take the core value on capture
    function automatic logic grabs_outputs(bsr_mode_e m);
        return (m == MODE_SAMPLE) || (m == MODE_INTEST);
    endfunction

    // update stage accepts the chain contents
    function automatic logic takes_update(bsr_mode_e m);
        return (m == MODE_SAMPLE) || (m == MODE_PRELOAD) ||
               (m == MODE_EXTEST) || (m == MODE_INTEST);
    endfunction

    // pins and core are isolated behind the update stage
    function automatic logic latch_drives(bsr_mode_e m);
        return (m == MODE_EXTEST) || (m == MODE_INTEST);
    endfunction

endpackage

// File: rtl/bsr_shift_chain.sv
module bsr_shift_chain
    import bsr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    localparam int LEN  = N_IN + 2 * N_OUT
) (
    input  logic             tck,
    input  logic             trst_n,
    input  bsr_mode_e        mode,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             scan_in,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [LEN-1:0]   chain_q,
    output logic             scan_out
);

    typedef struct packed {
        logic [LEN-1:0] sr;
    } chain_s;

    chain_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {scan_in, st_q.sr[LEN-1:1]};
        end else if (capture_en) begin
            if (grabs_inputs(mode)) begin
                for (int i = 0; i < N_IN; i++) begin
                    st_d.sr[i] = pad_in[i];
                end
            end
            if (grabs_outputs(mode)) begin
                for (int k = 0; k < N_OUT; k++) begin
                    st_d.sr[N_IN + 2*k]     = core_out[k];
                    st_d.sr[N_IN + 2*k + 1] = core_oe[k];
                end
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_q  = st_q.sr;
    assign scan_out = st_q.sr[0];

endmodule

// File: rtl/bsr_update_stage.sv
module bsr_update_stage
    import bsr_pkg::*;
#(
    parameter int LEN = 12
) (
    input  logic           tck,
    input  logic           trst_n,
    input  bsr_mode_e      mode,
    input  logic           update_en,
    input  logic [LEN-1:0] chain_q,
    output logic [LEN-1:0] upd_q
);

    typedef struct packed {
        logic [LEN-1:0] hold;
    } upd_s;

    upd_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_en && takes_update(mode)) begin
            st_d.hold = chain_q;
        end
    end

    // falling edge: loads after the rising-edge shift has settled
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_q = st_q.hold;

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
    import bsr_pkg::*;
#(
    parameter int               N_IN      = 4,
    parameter int               N_OUT     = 4,
    parameter logic [N_OUT-1:0] CLAMP_VAL = '0,
    localparam int              LEN       = N_IN + 2 * N_OUT
) (
    input  bsr_mode_e        mode,
    input  logic [LEN-1:0]   upd_q,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe,
    output logic [N_IN-1:0]  core_in
);

    logic from_latch;
    assign from_latch = latch_drives(mode);

    for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
        assign core_in[i] = from_latch ? upd_q[i] : pad_in[i];
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out_pair
        always_comb begin
            if (from_latch) begin
                pad_out[k] = upd_q[N_IN + 2*k];
                pad_oe[k]  = upd_q[N_IN + 2*k + 1];
            end else if (mode == MODE_CLAMP) begin
                pad_out[k] = CLAMP_VAL[k];
                pad_oe[k]  = 1'b1;
            end else if (mode == MODE_HIGHZ) begin
                pad_out[k] = 1'b0;
                pad_oe[k]  = 1'b0;
            end else begin
                pad_out[k] = core_out[k];
                pad_oe[k]  = core_oe[k];
            end
        end
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int               N_IN      = 4,
    parameter int               N_OUT     = 4,
    parameter logic [N_OUT-1:0] CLAMP_VAL = '0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic [2:0]       mode,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);

    localparam int LEN = N_IN + 2 * N_OUT;

    bsr_mode_e      mode_e;
    logic [LEN-1:0] chain_q;
    logic [LEN-1:0] upd_q;

    assign mode_e = bsr_mode_e'(mode);

    bsr_shift_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chain (
        .tck        (tck),
        .trst_n     (trst_n),
        .mode       (mode_e),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .scan_in    (scan_in),
        .pad_in     (pad_in),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .chain_q    (chain_q),
        .scan_out   (scan_out)
    );

    bsr_update_stage #(.LEN(LEN)) u_update (
        .tck       (tck),
        .trst_n    (trst_n),
        .mode      (mode_e),
        .update_en (update_en),
        .chain_q   (chain_q),
        .upd_q     (upd_q)
    );

    bsr_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT), .CLAMP_VAL(CLAMP_VAL)) u_mux (
        .mode     (mode_e),
        .upd_q    (upd_q),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .core_in  (core_in)
    );

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
    parameter int               N_IN      = 4,
    parameter int               N_OUT     = 4,
    parameter logic [N_OUT-1:0] CLAMP_VAL = '0
) (
    input logic             tck,
    input logic             trst_n,
    input logic [2:0]       mode,
    input logic             update_en,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] core_oe,
    input logic [N_IN-1:0]  pad_in,
    input logic [N_OUT-1:0] pad_out,
    input logic [N_OUT-1:0] pad_oe,
    input logic [N_IN-1:0]  core_in
);

    // R8
    extest_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == 3'd3 && $past(mode) == 3'd3 && !$past(update_en))
            |-> ($stable(pad_out) && $stable(pad_oe)));

    // R9
    normal_pass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == 3'd0)
            |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));

    // R10
    clamp_level_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == 3'd5) |-> (pad_out == CLAMP_VAL && pad_oe == '1));

    // R11
    highz_off_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == 3'd6) |-> (pad_oe == '0 && core_in == pad_in));

endmodule

bind bsr_chain bsr_chain_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .CLAMP_VAL(CLAMP_VAL)
) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .mode      (mode),
    .update_en (update_en),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .core_in   (core_in)
);

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;

    localparam int TCK_PERIOD = 10;
    localparam int NI = 2;
    localparam int NO = 2;
    localparam int L  = NI + 2 * NO;

    // {view mode, preload pattern, pad_out, pad_oe, core_in}
    // with core_out=10, core_oe=01, pad_in=01, CLAMP_VAL=01
    localparam logic [14:0] VEC [9] = '{
        {3'd3, 6'b110110, 2'b11, 2'b10, 2'b10},
        {3'd3, 6'b011001, 2'b10, 2'b01, 2'b01},
        {3'd2, 6'b101010, 2'b10, 2'b01, 2'b01},
        {3'd1, 6'b111111, 2'b10, 2'b01, 2'b01},
        {3'd0, 6'b000011, 2'b10, 2'b01, 2'b01},
        {3'd5, 6'b111100, 2'b01, 2'b11, 2'b01},
        {3'd6, 6'b110011, 2'b00, 2'b00, 2'b01},
        {3'd4, 6'b100101, 2'b01, 2'b10, 2'b01},
        {3'd7, 6'b010110, 2'b10, 2'b01, 2'b01}
    };
    localparam string VREQ [9] = '{"R6", "R6", "R5", "R4", "R9", "R10", "R11", "R7", "R9"};

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic          capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [NO-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
    logic [NI-1:0] pad_in = '0, core_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(TCK_PERIOD/2) tck = ~tck;

    bsr_chain #(.N_IN(NI), .N_OUT(NO), .CLAMP_VAL(2'b01)) u_dut (
        .tck(tck), .trst_n(trst_n), .mode(mode),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .scan_in(scan_in), .scan_out(scan_out),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req, input logic [1:0] po,
                            input logic [1:0] poe, input logic [1:0] ci);
        chk(req, {2'b00, pad_out, pad_oe, core_in}, {2'b00, po, poe, ci});
    endtask

    task automatic step_edge();
        @(negedge tck);
        #1;
    endtask

    task automatic do_shift(input logic [L-1:0] pat, output logic [L-1:0] got);
        for (int k = 0; k < L; k++) begin
            step_edge();
            got[k]   = scan_out;
            shift_en = 1'b1;
            scan_in  = pat[k];
        end
        step_edge();
        shift_en = 1'b0;
    endtask

    task automatic do_capture();
        step_edge();
        capture_en = 1'b1;
        step_edge();
        capture_en = 1'b0;
    endtask

    task automatic do_update();
        step_edge();
        update_en = 1'b1;
        step_edge();
        update_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(TCK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [L-1:0] got;
        logic [14:0]  v;

        // R1: reset state
        core_out = 2'b10; core_oe = 2'b01; pad_in = 2'b01;
        repeat (3) step_edge();
        chk("R1", {7'd0, scan_out}, 8'd0);
        trst_n = 1'b1;
        step_edge();
        chk("R1", {7'd0, scan_out}, 8'd0);
        chk_pins("R9", 2'b10, 2'b01, 2'b01);
        mode = 3'd3;
        #1;
        chk_pins("R1", 2'b00, 2'b00, 2'b00);

        // table: preload a pattern, then view pins under a mode
        for (int i = 0; i < 9; i++) begin
            v = VEC[i];
            mode = 3'd2;
            do_shift(v[11:6], got);
            do_update();
            mode = v[14:12];
            #2;
            chk_pins(VREQ[i], v[5:4], v[3:2], v[1:0]);
        end

        // R2: chain order and serial path
        mode = 3'd2;
        do_shift(6'b100110, got);
        do_shift(6'b000000, got);
        chk("R2", {2'b00, got}, {2'b00, 6'b100110});

        // R5: capture ignored in preload
        do_shift(6'b010101, got);
        do_capture();
        do_shift(6'b000000, got);
        chk("R5", {2'b00, got}, {2'b00, 6'b010101});

        // R4: sample capture
        mode = 3'd1; pad_in = 2'b10; core_out = 2'b01; core_oe = 2'b11;
        do_capture();
        do_shift(6'b000000, got);
        chk("R4", {2'b00, got}, {2'b00, 6'b101110});

        // R6: extest captures inputs only
        do_shift(6'b111100, got);
        mode = 3'd3; pad_in = 2'b01;
        do_capture();
        do_shift(6'b000000, got);
        chk("R6", {2'b00, got}, {2'b00, 6'b111101});

        // R7: intest captures outputs only
        do_shift(6'b000011, got);
        mode = 3'd4; core_out = 2'b10; core_oe = 2'b01;
        do_capture();
        do_shift(6'b000000, got);
        chk("R7", {2'b00, got}, {2'b00, 6'b011011});

        // R3: shift wins over capture
        mode = 3'd1;
        do_shift(6'b101010, got);
        step_edge();
        capture_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
        step_edge();
        capture_en = 1'b0; shift_en = 1'b0;
        do_shift(6'b000000, got);
        chk("R3", {2'b00, got}, {2'b00, 6'b110101});

        // R9: update and capture ignored in normal mode
        mode = 3'd2; pad_in = 2'b11;
        do_shift(6'b001100, got);
        do_update();
        do_shift(6'b111111, got);
        mode = 3'd0;
        do_update();
        do_capture();
        mode = 3'd3;
        #2;
        chk_pins("R9", 2'b01, 2'b01, 2'b00);
        do_shift(6'b110011, got);
        chk("R9", {2'b00, got}, {2'b00, 6'b111111});

        // R8: pins hold until the falling-edge update
        #2;
        chk_pins("R8", 2'b01, 2'b01, 2'b00);
        do_update();
        #2;
        chk_pins("R8", 2'b10, 2'b10, 2'b11);

        finish_run();
    end

endmodule